// File: doc/BRIEF.md
# Arithmetic and Logic Microoperation Unit

This block holds an accumulator register A and, on each clock edge where it is enabled, replaces A with the result of one single-cycle microoperation. The second operand B comes in on a port. A four-bit operation code selects the microoperation.

Four operations use the arithmetic path: add, subtract, increment and decrement. They all share one adder built as a chain of full adders. The operand in front of the adder is shaped per operation:

- B passes through for add.
- B is inverted and the carry-in is forced to 1 for subtract.
- A zero operand with carry-in 1 gives increment.
- An all-ones operand gives decrement.

The bit-manipulation path works independently on each bit position, with no carries between positions. It covers these operations:

- Setting the bits of A chosen by B.
- Flipping the bits of A chosen by B.
- Clearing the bits of A chosen by B.
- Masking A with B.
- Clearing A entirely.
- Loading A from B.

Arithmetic operations also update a carry flag and a signed-overflow flag. Every other operation leaves both flags as they were, so a controller can read them after a later bit-manipulation step. Multiply and divide take several cycles and belong to a sequencer built around this unit.

Top module: `muop_unit`

## Requirements
- R1: While rst_n is low, a_out, carry_out and ovf_out are all zero. All results are registered and appear after the rising clock edge that samples en high.
- R2: With en low, a_out, carry_out and ovf_out keep their values whatever op_code and b_in are.
- R3: op_code 1 (add) sets A to A+B modulo 2^WIDTH, and carry_out to the carry out of the most significant adder stage.
- R4: op_code 2 (subtract) sets A to A + ~B + 1 modulo 2^WIDTH. carry_out takes the adder carry out, so 1 means no borrow.
- R5: op_code 3 (increment) sets A to A+1, and op_code 4 (decrement) sets A to A-1. In both, carry_out is the adder carry out. For increment it is 1 only when A was all ones. For decrement the adder adds all ones, so carry_out is 1 unless A was zero.
- R6: After an arithmetic operation, ovf_out is 1 exactly when the two adder inputs had equal sign bits and the result's sign bit differs from them. For example, with WIDTH 8, 0x90 minus 0x30 gives 0x60 with ovf_out 1.
- R7: op_code 5 sets A to A | B, and op_code 6 sets A to A ^ B.
- R8: op_code 7 sets A to A & ~B, and op_code 8 sets A to A & B.
- R9: op_code 9 sets A to all zeros, whatever B is.
- R10: op_code 10 copies B into A.
- R11: op_codes 5 to 10 and the unused codes leave carry_out and ovf_out unchanged.
- R12: op_code 0 and op_codes 11 to 15 leave A unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Perform the selected microoperation on this edge |
| op_code | input | 4 | Microoperation select (see requirements) |
| b_in | input | WIDTH | Second operand B |
| a_out | output | WIDTH | Current value of register A |
| carry_out | output | 1 | Carry out of the last arithmetic operation |
| ovf_out | output | 1 | Signed overflow of the last arithmetic operation |

## Verification
The vector walk chains operations on the same register, so each step starts from the previous result.

The additions separate the flags from each other:
- Two positives whose sum turns negative set overflow without carry.
- A negative plus a positive that wraps sets carry without overflow.
- 0x80 plus 0x80 sets both flags.

The subtractions, increments and decrements cover the edge values:
- A borrow case and a no-borrow case.
- The 0x90 minus 0x30 overflow case.
- The increments 0x7F to 0x80 and 0xFF to 0x00.
- The decrements 0x80 to 0x7F and 0x00 to 0xFF.

Bit-manipulation steps are placed right after arithmetic steps that left nonzero flags, which shows that the flags are held. Their B patterns are chosen so that OR, XOR, AND-NOT and AND each give a different value. Directed tests then drive clear, subtract and load with en low, apply unused codes, and reset the unit in mid-run.

// File: rtl/muop_pkg.sv
package muop_pkg;

   typedef enum logic [3:0] {
      MOP_IDLE   = 4'd0,
      MOP_ADD    = 4'd1,
      MOP_SUB    = 4'd2,
      MOP_INC    = 4'd3,
      MOP_DEC    = 4'd4,
      MOP_BSET   = 4'd5,
      MOP_BFLIP  = 4'd6,
      MOP_BCLR   = 4'd7,
      MOP_MASK   = 4'd8,
      MOP_ZERO   = 4'd9,
      MOP_LOAD   = 4'd10
   } mop_e;

   function automatic logic mop_is_arith(input logic [3:0] code);
      return (code >= 4'd1) && (code <= 4'd4);
   endfunction

   function automatic logic mop_is_bitwise(input logic [3:0] code);
      return (code >= 4'd5) && (code <= 4'd10);
   endfunction

endpackage

// File: rtl/muop_operand.sv
// Shapes the second adder input and the carry-in for each arithmetic code.
module muop_operand #(
   parameter int WIDTH = 8
) (
   input  logic [3:0]       code,
   input  logic [WIDTH-1:0] b_val,
   output logic [WIDTH-1:0] addend,
   output logic             cin
);
   import muop_pkg::*;

   always_comb begin
      addend = b_val;
      cin    = 1'b0;
      unique case (mop_e'(code))
         MOP_ADD: begin addend = b_val;             cin = 1'b0; end
         MOP_SUB: begin addend = ~b_val;            cin = 1'b1; end
         MOP_INC: begin addend = '0;                cin = 1'b1; end
         MOP_DEC: begin addend = {WIDTH{1'b1}};     cin = 1'b0; end
         default: begin addend = b_val;             cin = 1'b0; end
      endcase
   end
endmodule

// File: rtl/muop_adder.sv
// WIDTH-bit adder: a cascade of full adders, or an inferred adder.
module muop_adder #(
   parameter int WIDTH      = 8,
   parameter bit USE_RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   generate
      if (USE_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            logic p;
            assign p           = x[i] ^ y[i];
            assign sum[i]      = p ^ chain[i];
            assign chain[i+1]  = (x[i] & y[i]) | (p & chain[i]);
         end
         assign cout = chain[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[MSB:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

   // Signed overflow: like-signed inputs, result sign differs.
   assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/muop_bitwise.sv
// Per-bit manipulation section; no signal crosses bit positions.
module muop_bitwise #(
   parameter int WIDTH = 8
) (
   input  logic [3:0]       code,
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   output logic [WIDTH-1:0] res
);
   import muop_pkg::*;

   function automatic logic bit_fn(input logic [3:0] c, input logic a, input logic b);
      case (mop_e'(c))
         MOP_BSET:  return a | b;
         MOP_BFLIP: return a ^ b;
         MOP_BCLR:  return a & ~b;
         MOP_MASK:  return a & b;
         MOP_ZERO:  return a ^ a;
         MOP_LOAD:  return b;
         default:   return a;
      endcase
   endfunction

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign res[i] = bit_fn(code, a_val[i], b_val[i]);
      end
   endgenerate
endmodule

// File: rtl/muop_unit.sv
module muop_unit #(
   parameter int WIDTH      = 8,
   parameter bit USE_RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic             carry_out,
   output logic             ovf_out
);
   import muop_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("muop_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] a_q;
   logic             c_q, v_q;
   logic [WIDTH-1:0] addend, sum, logic_res;
   logic             cin, cout, ovf;
   logic             do_arith, do_bits;

   muop_operand #(.WIDTH(WIDTH)) u_operand (
      .code   (op_code),
      .b_val  (b_in),
      .addend (addend),
      .cin    (cin)
   );

   muop_adder #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) u_adder (
      .x    (a_q),
      .y    (addend),
      .cin  (cin),
      .sum  (sum),
      .cout (cout),
      .ovf  (ovf)
   );

   muop_bitwise #(.WIDTH(WIDTH)) u_bits (
      .code  (op_code),
      .a_val (a_q),
      .b_val (b_in),
      .res   (logic_res)
   );

   assign do_arith = en && mop_is_arith(op_code);
   assign do_bits  = en && mop_is_bitwise(op_code);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         c_q <= 1'b0;
         v_q <= 1'b0;
      end else if (do_arith) begin
         a_q <= sum;
         c_q <= cout;
         v_q <= ovf;
      end else if (do_bits) begin
         a_q <= logic_res;
      end
   end

   assign a_out     = a_q;
   assign carry_out = c_q;
   assign ovf_out   = v_q;
endmodule

// File: rtl/muop_unit_chk.sv
module muop_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [3:0]       op_code,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] a_out,
   input logic             carry_out,
   input logic             ovf_out
);
   localparam int MSB = WIDTH - 1;

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(a_out) && $stable(carry_out) && $stable(ovf_out)));

   // R3
   add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_code == 4'd1) |=> (a_out == WIDTH'($past(a_out) + $past(b_in))));

   // R6
   sub_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_code == 4'd2) |=>
         (ovf_out == (($past(a_out[MSB]) != $past(b_in[MSB])) && (a_out[MSB] != $past(a_out[MSB])))));

   // R8
   mask_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_code == 4'd8) |=> (a_out == ($past(a_out) & $past(b_in))));

   // R9
   zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_code == 4'd9) |=> (a_out == '0));

   // R11
   flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op_code == 4'd0 || op_code >= 4'd5)) |=> ($stable(carry_out) && $stable(ovf_out)));

   // R12
   unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op_code == 4'd0 || op_code >= 4'd11)) |=> $stable(a_out));
endmodule

bind muop_unit muop_unit_chk #(.WIDTH(WIDTH)) u_muop_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .op_code   (op_code),
   .b_in      (b_in),
   .a_out     (a_out),
   .carry_out (carry_out),
   .ovf_out   (ovf_out)
);

// File: tb/test_muop_unit.sv
`timescale 1ns/1ps
module test_muop_unit;
   localparam int W = 8;
   localparam int NV = 23;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic [3:0]   op_code = 4'd0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] a_out;
   logic         carry_out, ovf_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   muop_unit #(.WIDTH(W)) i_muop_unit (
      .clk(clk), .rst_n(rst_n), .en(en), .op_code(op_code), .b_in(b_in),
      .a_out(a_out), .carry_out(carry_out), .ovf_out(ovf_out)
   );

   // {op, b, expected A, expected carry, expected overflow}; chained from A = 00.
   localparam logic [21:0] VEC [NV] = '{
      {4'd10, 8'h3C, 8'h3C, 1'b0, 1'b0},  // R10 load
      {4'd1,  8'h25, 8'h61, 1'b0, 1'b0},  // R3
      {4'd1,  8'h7F, 8'hE0, 1'b0, 1'b1},  // R3/R6 pos+pos -> neg
      {4'd1,  8'h30, 8'h10, 1'b1, 1'b0},  // R3 carry, no overflow
      {4'd2,  8'h20, 8'hF0, 1'b0, 1'b0},  // R4 borrow
      {4'd10, 8'h90, 8'h90, 1'b0, 1'b0},  // R10
      {4'd2,  8'h30, 8'h60, 1'b1, 1'b1},  // R4/R6 overflow case
      {4'd5,  8'h0F, 8'h6F, 1'b1, 1'b1},  // R7 OR, R11 flags kept
      {4'd6,  8'hFF, 8'h90, 1'b1, 1'b1},  // R7 XOR
      {4'd7,  8'h10, 8'h80, 1'b1, 1'b1},  // R8 A&~B
      {4'd4,  8'h00, 8'h7F, 1'b1, 1'b1},  // R5 dec 80 -> 7F
      {4'd3,  8'h00, 8'h80, 1'b0, 1'b1},  // R5 inc 7F -> 80
      {4'd8,  8'hF0, 8'h80, 1'b0, 1'b1},  // R8 mask
      {4'd3,  8'h00, 8'h81, 1'b0, 1'b0},  // R5
      {4'd10, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R10
      {4'd3,  8'h00, 8'h00, 1'b1, 1'b0},  // R5 inc wrap
      {4'd4,  8'h00, 8'hFF, 1'b0, 1'b0},  // R5 dec from zero
      {4'd0,  8'h12, 8'hFF, 1'b0, 1'b0},  // R12 idle code
      {4'd14, 8'h00, 8'hFF, 1'b0, 1'b0},  // R12 unused code
      {4'd9,  8'h55, 8'h00, 1'b0, 1'b0},  // R9 clear
      {4'd2,  8'h00, 8'h00, 1'b1, 1'b0},  // R4 0-0 no borrow
      {4'd1,  8'h80, 8'h80, 1'b0, 1'b0},  // R3
      {4'd1,  8'h80, 8'h00, 1'b1, 1'b1}   // R3/R6 both flags
   };

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3, 4'd4: return "R5";
         4'd5, 4'd6: return "R7";
         4'd7, 4'd8: return "R8";
         4'd9: return "R9";
         4'd10: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] ea, input logic ec, input logic ev);
      n_run++;
      if (a_out !== ea || carry_out !== ec || ovf_out !== ev) begin
         n_fail++;
         $display("FAIL %s: a=%h c=%b v=%b expected a=%h c=%b v=%b",
                  req, a_out, carry_out, ovf_out, ea, ec, ev);
      end
   endtask

   // Inputs set just after a falling edge, result sampled at the next falling edge.
   task automatic apply(input logic e, input logic [3:0] c, input logic [W-1:0] b);
      en = e; op_code = c; b_in = b;
      @(negedge clk);
      en = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1", 8'h00, 1'b0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(1'b1, VEC[i][21:18], VEC[i][17:10]);
         check(req_of(VEC[i][21:18]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
         if (VEC[i][21:18] == 4'd0 || VEC[i][21:18] >= 4'd5)
            check("R11", VEC[i][9:2], VEC[i][1], VEC[i][0]);
         if (VEC[i][21:18] <= 4'd4 && VEC[i][21:18] != 4'd0)
            check("R6", VEC[i][9:2], VEC[i][1], VEC[i][0]);
      end
      // A = 00, carry 1, overflow 1 here.

      apply(1'b1, 4'd10, 8'hA5);
      check("R10", 8'hA5, 1'b1, 1'b1);
      apply(1'b0, 4'd9, 8'h00);
      check("R2", 8'hA5, 1'b1, 1'b1);
      apply(1'b0, 4'd2, 8'h01);
      check("R2", 8'hA5, 1'b1, 1'b1);
      apply(1'b0, 4'd10, 8'h3C);
      check("R2", 8'hA5, 1'b1, 1'b1);
      apply(1'b1, 4'd15, 8'hFF);
      check("R12", 8'hA5, 1'b1, 1'b1);
      apply(1'b1, 4'd11, 8'h00);
      check("R12", 8'hA5, 1'b1, 1'b1);
      apply(1'b1, 4'd9, 8'hFF);
      check("R9", 8'h00, 1'b1, 1'b1);

      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 8'h00, 1'b0, 1'b0);
      rst_n = 1'b1;
      apply(1'b1, 4'd4, 8'h00);
      check("R5", 8'hFF, 1'b0, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule